// File: doc/BRIEF.md
# Accumulator Register-Reference Execution Unit

This block executes the register-only instructions of a small accumulator machine. These instructions have no memory operand. They act on a 16-bit accumulator and a one-bit extend flag. The unit checks whether the current instruction word belongs to this class and whether the control sequencer is in the fourth timing step (T3). If both hold, the unit decodes the twelve low instruction bits as one-hot operation selects. It then produces the updated accumulator and extend flag, a request to skip the next instruction, a request to halt, and a request to clear the sequence counter.

The surrounding control path supplies the current accumulator, the extend flag, the instruction word and the T3 step flag. It then writes the results back. In the default configuration the results are registered, so they appear one clock after the enabled cycle. A parameter can select a purely combinational variant instead. When the unit is not enabled it passes the accumulator and extend flag through unchanged and raises no request.

Top module: `rr_exec_unit`

## Requirements
- R1: The unit is enabled only when instruction bit 15 is 0, bits 14..12 equal 3'b111 and `phase_t3` is 1. In any other cycle `acc_nxt` equals `acc_in`, `ext_nxt` equals `ext_in`, and `skip_req`, `halt_req` and `sc_clr` are 0.
- R2: With the default registered output stage, every result appears one clock after the enabled cycle, and `sc_clr` is 1 for exactly that one cycle.
- R3: Bit 11 (word 16'h7800) clears the accumulator. Bit 10 (16'h7400) clears the extend flag.
- R4: Bit 9 (16'h7200) inverts every accumulator bit. Bit 8 (16'h7100) inverts the extend flag.
- R5: Bit 7 (16'h7080) rotates the 17-bit pair right. The extend flag enters accumulator bit 15 and the old accumulator bit 0 becomes the extend flag.
- R6: Bit 6 (16'h7040) rotates the pair left. The extend flag enters accumulator bit 0 and the old accumulator bit 15 becomes the extend flag.
- R7: Bit 5 (16'h7020) adds one to the accumulator modulo 2^16 and leaves the extend flag unchanged.
- R8: The skip tests are: bit 4 (16'h7010) when accumulator bit 15 is 0; bit 3 (16'h7008) when accumulator bit 15 is 1; bit 2 (16'h7004) when the accumulator is zero; bit 1 (16'h7002) when the extend flag is 0.
- R9: `skip_req` is the OR of all selected skip tests. The tests use `acc_in` and `ext_in` as they were before the update.
- R10: Bit 0 (16'h7001) raises `halt_req`. No other bit raises it.
- R11: When several operation bits are set, they take effect in this order: clear, complement, rotate right, rotate left, increment.
- R12: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_word | input | WORD_W | Current instruction word |
| phase_t3 | input | 1 | Sequencer is in step T3 |
| acc_in | input | WORD_W | Accumulator before update |
| ext_in | input | 1 | Extend flag before update |
| acc_nxt | output | WORD_W | Accumulator after update |
| ext_nxt | output | 1 | Extend flag after update |
| skip_req | output | 1 | Advance program counter past next instruction |
| halt_req | output | 1 | Clear the run flag |
| sc_clr | output | 1 | Clear the sequence counter |

## Verification
The assertions assume that `instr_word`, `phase_t3`, `acc_in` and `ext_in` are stable across each rising edge. They also assume the inputs hold defined values whenever reset is released. The bench meets both conditions: it changes every input only on the falling edge, keeps all inputs at zero during reset, and samples each result on the falling edge after the edge that registers it. Disabled cycles use words with the wrong opcode, words with bit 15 set, and words with T3 low, so that the enable decode is tested from all three directions.

// File: rtl/rr_unit_pkg.sv
package rr_unit_pkg;
   // one-hot select positions inside the low instruction field
   localparam int BIT_CLR_A = 11;
   localparam int BIT_CLR_E = 10;
   localparam int BIT_CPL_A = 9;
   localparam int BIT_CPL_E = 8;
   localparam int BIT_ROT_R = 7;
   localparam int BIT_ROT_L = 6;
   localparam int BIT_INC_A = 5;
   localparam int BIT_SK_PL = 4;
   localparam int BIT_SK_MI = 3;
   localparam int BIT_SK_ZA = 2;
   localparam int BIT_SK_ZE = 1;
   localparam int BIT_STOP  = 0;
   localparam int SEL_W     = 12;
   localparam logic [2:0] OPC_REGREF = 3'b111;

   typedef struct packed {
      logic clr_a;
      logic clr_e;
      logic cpl_a;
      logic cpl_e;
      logic rot_r;
      logic rot_l;
      logic inc_a;
      logic sk_pl;
      logic sk_mi;
      logic sk_za;
      logic sk_ze;
      logic stop;
   } rr_ops_t;
endpackage

// File: rtl/rr_decode.sv
module rr_decode
   import rr_unit_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] instr_word,
   input  logic              phase_t3,
   output logic              en,
   output rr_ops_t           ops
);
   localparam int TOP = WORD_W - 1;
   localparam int OPC_LO = TOP - 3;

   if (WORD_W < 16) begin : g_bad_width
      $error("rr_decode: WORD_W must be at least 16");
   end

   logic [2:0] opc;
   logic       ind;
   logic [SEL_W-1:0] sel;

   assign opc = instr_word[OPC_LO +: 3];
   assign ind = instr_word[TOP];
   assign sel = instr_word[SEL_W-1:0];
   assign en  = phase_t3 && !ind && (opc == OPC_REGREF);

   always_comb begin
      ops       = '0;
      if (en) begin
         ops.clr_a = sel[BIT_CLR_A];
         ops.clr_e = sel[BIT_CLR_E];
         ops.cpl_a = sel[BIT_CPL_A];
         ops.cpl_e = sel[BIT_CPL_E];
         ops.rot_r = sel[BIT_ROT_R];
         ops.rot_l = sel[BIT_ROT_L];
         ops.inc_a = sel[BIT_INC_A];
         ops.sk_pl = sel[BIT_SK_PL];
         ops.sk_mi = sel[BIT_SK_MI];
         ops.sk_za = sel[BIT_SK_ZA];
         ops.sk_ze = sel[BIT_SK_ZE];
         ops.stop  = sel[BIT_STOP];
      end
   end

   // R10: the stop request can only come from an enabled word
   always_comb begin
      a_r10_stop_needs_en : assert (!ops.stop || en);
   end
endmodule

// File: rtl/rr_alu.sv
module rr_alu
   import rr_unit_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  rr_ops_t           ops,
   input  logic [WORD_W-1:0] acc_i,
   input  logic              ext_i,
   output logic [WORD_W-1:0] acc_o,
   output logic              ext_o
);
   localparam int MSB = WORD_W - 1;
   localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

   logic [WORD_W-1:0] a_clr, a_cpl, a_rr, a_rl;
   logic              e_clr, e_cpl, e_rr, e_rl;

   // stage 1: clear
   always_comb begin
      a_clr = ops.clr_a ? '0 : acc_i;
      e_clr = ops.clr_e ? 1'b0 : ext_i;
   end

   // stage 2: complement
   always_comb begin
      a_cpl = ops.cpl_a ? ~a_clr : a_clr;
      e_cpl = ops.cpl_e ? ~e_clr : e_clr;
   end

   // stage 3: rotate right through the extend flag
   always_comb begin
      if (ops.rot_r) begin
         a_rr = {e_cpl, a_cpl[MSB:1]};
         e_rr = a_cpl[0];
      end else begin
         a_rr = a_cpl;
         e_rr = e_cpl;
      end
   end

   // stage 4: rotate left through the extend flag
   always_comb begin
      if (ops.rot_l) begin
         a_rl = {a_rr[MSB-1:0], e_rr};
         e_rl = a_rr[MSB];
      end else begin
         a_rl = a_rr;
         e_rl = e_rr;
      end
   end

   // stage 5: increment, wraps, flag untouched
   assign acc_o = ops.inc_a ? a_rl + ONE : a_rl;
   assign ext_o = e_rl;

   // R7: increment never touches the flag when used alone
   always_comb begin
      a_r7_inc_keeps_flag : assert (!(ops.inc_a && !ops.clr_e && !ops.cpl_e
                                      && !ops.rot_r && !ops.rot_l) || ext_o == ext_i);
   end
endmodule

// File: rtl/rr_skip.sv
module rr_skip
   import rr_unit_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  rr_ops_t           ops,
   input  logic [WORD_W-1:0] acc_i,
   input  logic              ext_i,
   output logic              skip
);
   localparam int MSB = WORD_W - 1;
   localparam int N_TEST = 4;

   logic [N_TEST-1:0] sel_v, cond_v, hit_v;

   assign sel_v  = {ops.sk_pl, ops.sk_mi, ops.sk_za, ops.sk_ze};
   assign cond_v = {!acc_i[MSB], acc_i[MSB], (acc_i == '0), !ext_i};

   for (genvar k = 0; k < N_TEST; k++) begin : g_test
      assign hit_v[k] = sel_v[k] & cond_v[k];
   end

   assign skip = |hit_v;

   // R8: plus and minus tests can never both succeed
   always_comb begin
      a_r8_sign_tests_exclusive : assert (!(hit_v[3] && hit_v[2]));
   end
endmodule

// File: rtl/rr_exec_unit.sv
module rr_exec_unit
   import rr_unit_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter bit OUT_STAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] instr_word,
   input  logic              phase_t3,
   input  logic [WORD_W-1:0] acc_in,
   input  logic              ext_in,
   output logic [WORD_W-1:0] acc_nxt,
   output logic              ext_nxt,
   output logic              skip_req,
   output logic              halt_req,
   output logic              sc_clr
);
   localparam int TOP = WORD_W - 1;

   logic              en;
   rr_ops_t           ops;
   logic [WORD_W-1:0] acc_c;
   logic              ext_c, skip_c;

   rr_decode #(.WORD_W(WORD_W)) u_dec (
      .instr_word(instr_word), .phase_t3(phase_t3), .en(en), .ops(ops)
   );

   rr_alu #(.WORD_W(WORD_W)) u_alu (
      .ops(ops), .acc_i(acc_in), .ext_i(ext_in), .acc_o(acc_c), .ext_o(ext_c)
   );

   rr_skip #(.WORD_W(WORD_W)) u_skip (
      .ops(ops), .acc_i(acc_in), .ext_i(ext_in), .skip(skip_c)
   );

   if (OUT_STAGE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_nxt  <= '0;
            ext_nxt  <= 1'b0;
            skip_req <= 1'b0;
            halt_req <= 1'b0;
            sc_clr   <= 1'b0;
         end else begin
            acc_nxt  <= acc_c;
            ext_nxt  <= ext_c;
            skip_req <= skip_c;
            halt_req <= ops.stop;
            sc_clr   <= en;
         end
      end

      logic port_en;
      assign port_en = phase_t3 && !instr_word[TOP] && (instr_word[TOP-1 -: 3] == 3'b111);

      a_r2_sc_clr_follows : assert property (@(posedge clk) disable iff (!rst_n)
         port_en |=> sc_clr);
      a_r1_sc_clr_idle : assert property (@(posedge clk) disable iff (!rst_n)
         !port_en |=> !sc_clr);
      a_r1_pass_through : assert property (@(posedge clk) disable iff (!rst_n)
         !port_en |=> (acc_nxt == $past(acc_in)) && (ext_nxt == $past(ext_in)));
      a_r1_no_req_idle : assert property (@(posedge clk) disable iff (!rst_n)
         !port_en |=> !skip_req && !halt_req);
      a_r10_halt_raised : assert property (@(posedge clk) disable iff (!rst_n)
         (port_en && instr_word[0]) |=> halt_req);
      a_r3_clear_acc_alone : assert property (@(posedge clk) disable iff (!rst_n)
         (port_en && instr_word[11:0] == 12'h800) |=> (acc_nxt == '0));
      a_r9_skip_on_zero : assert property (@(posedge clk) disable iff (!rst_n)
         (port_en && instr_word[2] && acc_in == '0) |=> skip_req);
   end else begin : g_comb
      assign acc_nxt  = rst_n ? acc_c : '0;
      assign ext_nxt  = rst_n && ext_c;
      assign skip_req = rst_n && skip_c;
      assign halt_req = rst_n && ops.stop;
      assign sc_clr   = rst_n && en;

      always_comb begin
         a_r1_comb_idle : assert (sc_clr || (!skip_req && !halt_req));
      end
   end
endmodule

// File: tb/rr_exec_unit_test.sv
module rr_exec_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr_word = '0;
   logic        phase_t3 = 1'b0;
   logic [15:0] acc_in = '0;
   logic        ext_in = 1'b0;
   logic [15:0] acc_nxt;
   logic        ext_nxt, skip_req, halt_req, sc_clr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rr_exec_unit uut (
      .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .phase_t3(phase_t3),
      .acc_in(acc_in), .ext_in(ext_in), .acc_nxt(acc_nxt), .ext_nxt(ext_nxt),
      .skip_req(skip_req), .halt_req(halt_req), .sc_clr(sc_clr)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive on falling edge, result registered at rising edge, sample on next falling edge
   task automatic run(input logic [15:0] w, input logic t3,
                      input logic [15:0] a, input logic e);
      instr_word = w; phase_t3 = t3; acc_in = a; ext_in = e;
      @(negedge clk);
   endtask

   task automatic expect_out(input string req, input logic [15:0] a, input logic e,
                             input logic sk, input logic h, input logic sc);
      chk(req, "acc", {16'h0, acc_nxt}, {16'h0, a});
      chk(req, "ext", {31'h0, ext_nxt}, {31'h0, e});
      chk(req, "skip", {31'h0, skip_req}, {31'h0, sk});
      chk(req, "halt", {31'h0, halt_req}, {31'h0, h});
      chk(req, "sc_clr", {31'h0, sc_clr}, {31'h0, sc});
   endtask

   task automatic t_reset();
      expect_out("R12", 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_clear_cpl();
      run(16'h7800, 1, 16'h1234, 1); expect_out("R3", 16'h0000, 1, 0, 0, 1);
      run(16'h7400, 1, 16'h1234, 1); expect_out("R3", 16'h1234, 0, 0, 0, 1);
      run(16'h7200, 1, 16'h00F0, 0); expect_out("R4", 16'hFF0F, 0, 0, 0, 1);
      run(16'h7100, 1, 16'h00F0, 0); expect_out("R4", 16'h00F0, 1, 0, 0, 1);
   endtask

   task automatic t_rotate();
      run(16'h7080, 1, 16'h0001, 1); expect_out("R5", 16'h8000, 1, 0, 0, 1);
      run(16'h7080, 1, 16'h8002, 0); expect_out("R5", 16'h4001, 0, 0, 0, 1);
      run(16'h7040, 1, 16'h8000, 0); expect_out("R6", 16'h0000, 1, 0, 0, 1);
      run(16'h7040, 1, 16'h4001, 1); expect_out("R6", 16'h8003, 0, 0, 0, 1);
   endtask

   task automatic t_increment();
      run(16'h7020, 1, 16'hFFFF, 1); expect_out("R7", 16'h0000, 1, 0, 0, 1);
      run(16'h7020, 1, 16'h00FF, 0); expect_out("R7", 16'h0100, 0, 0, 0, 1);
   endtask

   task automatic t_skips();
      run(16'h7010, 1, 16'h7FFF, 0); expect_out("R8", 16'h7FFF, 0, 1, 0, 1);
      run(16'h7010, 1, 16'h8000, 0); expect_out("R8", 16'h8000, 0, 0, 0, 1);
      run(16'h7008, 1, 16'h8000, 0); expect_out("R8", 16'h8000, 0, 1, 0, 1);
      run(16'h7008, 1, 16'h0001, 0); expect_out("R8", 16'h0001, 0, 0, 0, 1);
      run(16'h7004, 1, 16'h0000, 1); expect_out("R8", 16'h0000, 1, 1, 0, 1);
      run(16'h7004, 1, 16'h0100, 1); expect_out("R8", 16'h0100, 1, 0, 0, 1);
      run(16'h7002, 1, 16'h5555, 0); expect_out("R8", 16'h5555, 0, 1, 0, 1);
      run(16'h7002, 1, 16'h5555, 1); expect_out("R8", 16'h5555, 1, 0, 0, 1);
   endtask

   task automatic t_skip_or_pre();
      // SZA + SNA: acc nonzero negative -> minus test hits
      run(16'h700C, 1, 16'h9000, 1); expect_out("R9", 16'h9000, 1, 1, 0, 1);
      // CLA with SZA: test sees the old nonzero value, no skip
      run(16'h7804, 1, 16'h0042, 0); expect_out("R9", 16'h0000, 0, 0, 0, 1);
      // CME with SZE: old flag is 0, so skip even though new flag is 1
      run(16'h7102, 1, 16'h0042, 0); expect_out("R9", 16'h0042, 1, 1, 0, 1);
   endtask

   task automatic t_halt();
      run(16'h7001, 1, 16'h0ABC, 1); expect_out("R10", 16'h0ABC, 1, 0, 1, 1);
      run(16'h7FFE, 1, 16'h0ABC, 1); chk("R10", "no halt", {31'h0, halt_req}, 32'h0);
   endtask

   task automatic t_order();
      // clear then complement: FFFF, E 1
      run(16'h7F00, 1, 16'h1234, 0); expect_out("R11", 16'hFFFF, 1, 0, 0, 1);
      // complement then increment: ~0x0001 + 1 = 0xFFFF
      run(16'h7220, 1, 16'h0001, 0); expect_out("R11", 16'hFFFF, 0, 0, 0, 1);
      // rotate right then left restores
      run(16'h70C0, 1, 16'hA5A5, 1); expect_out("R11", 16'hA5A5, 1, 0, 0, 1);
      // rotate left then increment: 0x8000,E0 -> 0x0000,E1 -> 0x0001
      run(16'h7060, 1, 16'h8000, 0); expect_out("R11", 16'h0001, 1, 0, 0, 1);
   endtask

   task automatic t_disabled();
      run(16'h7800, 0, 16'h1234, 1); expect_out("R1", 16'h1234, 1, 0, 0, 0);
      run(16'hF801, 1, 16'h2222, 0); expect_out("R1", 16'h2222, 0, 0, 0, 0);
      run(16'h6804, 1, 16'h0000, 0); expect_out("R1", 16'h0000, 0, 0, 0, 0);
   endtask

   task automatic t_single_cycle();
      run(16'h7020, 1, 16'h0010, 0); chk("R2", "sc_clr on", {31'h0, sc_clr}, 32'h1);
      run(16'h0000, 0, 16'h0010, 0); chk("R2", "sc_clr off", {31'h0, sc_clr}, 32'h0);
      chk("R2", "acc after idle", {16'h0, acc_nxt}, 32'h0010);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_clear_cpl();
      t_rotate();
      t_increment();
      t_skips();
      t_skip_or_pre();
      t_halt();
      t_order();
      t_disabled();
      t_single_cycle();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule